// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Generator

This block produces an edge-aligned pulse-width-modulated output from a free-running up-counter. A period value sets how many counter steps make one cycle, and a duty value sets how many of those steps the output spends at its on level. The counter only steps on clocks picked out by a programmable prescaler, and that enable is also driven out so that neighbouring logic can share the same time base.

Software writes the period and duty through two simple write strobes into shadow registers. The shadow values move into the active compare registers only when a period ends, so a cycle that is under way always finishes with the settings it began with. A polarity input chooses the level of the output: the on level is the inverse of the polarity input and the off level equals it. A one-clock flag marks the start of each new period. Two corner cases are resolved with care. A duty at or above the period keeps the output on for the whole cycle. A duty of zero keeps it off from the first clock of the cycle, with no short on pulse at the boundary.

Top module: `bufpwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_out` equals the inverse of `pol` (on level) and `period_flag` is 0.
- R2: With `pre_ratio` = N (N >= 2), `cnt_en` is high for exactly one clock in every N clocks; with `pre_ratio` of 0 or 1 it is high on every clock.
- R3: The step counter runs from 1 up to the active period P and returns to 1 on the step where it reaches P, so one period lasts P x N clocks; a period value of 0 behaves as 1.
- R4: After a period ends, `pwm_out` sits at the on level (inverse of `pol`) and moves to the off level (equal to `pol`) on the step where the counter equals the active duty D, giving D x N on clocks per period when 0 < D < P.
- R5: When the period end and the duty match fall on the same step (D = P), the period end decides the level and the output stays on for the whole period.
- R6: Any duty D greater than P gives an output that is on for every clock of the period.
- R7: A duty of 0 gives an output that is off for every clock of the period, starting on the first clock after the boundary, with no on pulse in between.
- R8: Writes to the period or duty take effect at the first period end that follows the clock of the write; a write in the same clock as a period end takes effect one period later.
- R9: `period_flag` is high for exactly one clock, the first clock of each new period, and low for the rest of the period (for periods of more than one clock).
- R10: A change of `pol` inverts `pwm_out` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pol | input | 1 | Polarity; off level of the output |
| pre_ratio | input | PRE_W | Prescaler ratio; 0 and 1 both mean every clock |
| per_wr | input | 1 | Write strobe for the period shadow |
| per_din | input | CNT_W | Period value to write |
| duty_wr | input | 1 | Write strobe for the duty shadow |
| duty_din | input | CNT_W | Duty value to write |
| pwm_out | output | 1 | PWM output |
| period_flag | output | 1 | One-clock pulse at the start of each period |
| cnt_en | output | 1 | Prescaled step enable |

## Verification
The two events that can land on one step are the period end and the duty match, and the shadow-to-active copy always lands on the period end as well. The bench provokes the coincidence by setting the duty equal to the period, and the copy-plus-boundary case by switching from full on straight to a duty of zero and by writing in the very clock of a period end. Each case is judged by counting on-level clocks over one full period aligned to the flag, which must equal the period length, zero, or the old duty respectively.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    // Events seen by the compare logic on one counter step
    typedef struct packed {
        logic per_hit;
        logic duty_hit;
    } hit_t;

    // Next on/off state of the output stage; the period end wins over
    // the duty match, and a zero duty at the boundary forces off.
    function automatic logic next_on(hit_t h, logic cur_on, logic nxt_duty_zero);
        logic r;
        if (h.per_hit)
            r = ~nxt_duty_zero;
        else if (h.duty_hit)
            r = 1'b0;
        else
            r = cur_on;
        return r;
    endfunction

endpackage

// File: rtl/bpwm_prescaler.sv
module bpwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] ratio,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;

    assign lim  = (ratio == '0) ? '0 : ratio - PRE_W'(1);
    assign tick = (pcnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PRE_W'(1);
    end

    // R2: with a ratio above one, two enables never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> (!tick || ratio != $past(ratio)));

endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_din,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_din,
    input  logic             load,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_duty,
    output logic             nxt_duty_zero
);
    localparam logic [CNT_W-1:0] PER_RST  = CNT_W'(1);
    localparam logic [CNT_W-1:0] DUTY_RST = '1;

    logic [CNT_W-1:0] sh_per;
    logic [CNT_W-1:0] sh_duty;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_per  <= PER_RST;
            sh_duty <= DUTY_RST;
        end else begin
            if (per_wr)
                sh_per <= per_din;
            if (duty_wr)
                sh_duty <= duty_din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_per  <= PER_RST;
            act_duty <= DUTY_RST;
        end else if (load) begin
            act_per  <= sh_per;
            act_duty <= sh_duty;
        end
    end

    assign nxt_duty_zero = (sh_duty == '0);

    // R8: active compare values move only on a period end
    a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act_per) && $stable(act_duty)));

    // R8: a load takes the shadow value held before the write in that clock
    a_r8_load_prior_shadow: assert property (@(posedge clk) disable iff (rst)
        load |=> (act_duty == $past(sh_duty) && act_per == $past(sh_per)));

endmodule

// File: rtl/bpwm_core.sv
module bpwm_core
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_per,
    input  logic [CNT_W-1:0] act_duty,
    input  logic             nxt_duty_zero,
    output logic             per_end,
    output logic             on,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    hit_t             hit;

    assign hit.per_hit  = tick && (cnt >= act_per);
    assign hit.duty_hit = tick && (cnt == act_duty);
    assign per_end      = hit.per_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CNT_W'(1);
            on   <= 1'b1;
            flag <= 1'b0;
        end else begin
            flag <= hit.per_hit;
            on   <= next_on(hit, on, nxt_duty_zero);
            if (hit.per_hit)
                cnt <= CNT_W'(1);
            else if (tick)
                cnt <= cnt + CNT_W'(1);
        end
    end

    // R3: the counter restarts at one after a period end
    a_r3_wrap_to_one: assert property (@(posedge clk) disable iff (rst)
        hit.per_hit |=> (cnt == CNT_W'(1)));

    // R3: without an enable the counter holds
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R3: the counter never reads zero
    a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    // R4: a duty match away from the period end turns the output off
    a_r4_duty_off: assert property (@(posedge clk) disable iff (rst)
        (hit.duty_hit && !hit.per_hit) |=> !on);

    // R5: on a shared step the period end keeps the output on
    a_r5_period_wins: assert property (@(posedge clk) disable iff (rst)
        (hit.per_hit && hit.duty_hit && !nxt_duty_zero) |=> on);

    // R7: a zero duty loaded at the boundary forces off at once
    a_r7_zero_duty_off: assert property (@(posedge clk) disable iff (rst)
        (hit.per_hit && nxt_duty_zero) |=> !on);

endmodule

// File: rtl/bufpwm_gen.sv
module bufpwm_gen #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol,
    input  logic [PRE_W-1:0] pre_ratio,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_din,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_din,
    output logic             pwm_out,
    output logic             period_flag,
    output logic             cnt_en
);
    logic             tick;
    logic             per_end;
    logic             on;
    logic             nxt_duty_zero;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_duty;

    bpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .ratio (pre_ratio),
        .tick  (tick)
    );

    bpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .per_wr        (per_wr),
        .per_din       (per_din),
        .duty_wr       (duty_wr),
        .duty_din      (duty_din),
        .load          (per_end),
        .act_per       (act_per),
        .act_duty      (act_duty),
        .nxt_duty_zero (nxt_duty_zero)
    );

    bpwm_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .act_per       (act_per),
        .act_duty      (act_duty),
        .nxt_duty_zero (nxt_duty_zero),
        .per_end       (per_end),
        .on            (on),
        .flag          (flag_q)
    );

    logic flag_q;

    // On level is the inverse of pol, off level equals pol
    assign pwm_out     = on ^ pol;
    assign period_flag = flag_q;
    assign cnt_en      = tick;

    // R9: the flag follows every period end by one clock
    a_r9_flag_after_end: assert property (@(posedge clk) disable iff (rst)
        per_end |=> period_flag);

endmodule

// File: tb/bufpwm_gen_tb.sv
module bufpwm_gen_tb;
    localparam int CW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pol = 1'b1;
    logic [PW-1:0] pre_ratio = 8'd1;
    logic          per_wr = 1'b0;
    logic [CW-1:0] per_din = '0;
    logic          duty_wr = 1'b0;
    logic [CW-1:0] duty_din = '0;
    logic          pwm_out;
    logic          period_flag;
    logic          cnt_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    bufpwm_gen #(.CNT_W(CW), .PRE_W(PW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .pol         (pol),
        .pre_ratio   (pre_ratio),
        .per_wr      (per_wr),
        .per_din     (per_din),
        .duty_wr     (duty_wr),
        .duty_din    (duty_din),
        .pwm_out     (pwm_out),
        .period_flag (period_flag),
        .cnt_en      (cnt_en)
    );

    typedef struct packed {
        logic [7:0]  r;
        logic [15:0] p;
        logic [15:0] d;
        logic        pl;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 16'd8, 16'd3,  1'b0},
        '{8'd1, 16'd8, 16'd8,  1'b0},
        '{8'd1, 16'd8, 16'd12, 1'b1},
        '{8'd1, 16'd8, 16'd0,  1'b0},
        '{8'd2, 16'd5, 16'd2,  1'b1},
        '{8'd3, 16'd4, 16'd1,  1'b0},
        '{8'd1, 16'd1, 16'd0,  1'b1},
        '{8'd4, 16'd3, 16'd3,  1'b1},
        '{8'd1, 16'd0, 16'd1,  1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_flag();
        do @(negedge clk); while (!period_flag);
    endtask

    task automatic program_cfg(input int r, input int p, input int d, input logic pl);
        @(negedge clk);
        pol       = pl;
        pre_ratio = PW'(r);
        per_wr    = 1'b1;
        per_din   = CW'(p);
        duty_wr   = 1'b1;
        duty_din  = CW'(d);
        @(negedge clk);
        per_wr  = 1'b0;
        duty_wr = 1'b0;
        wait_flag();
    endtask

    // Starts on the flag sample; counts on-level samples over len clocks,
    // optionally writing a duty at sample index wr_idx.
    task automatic probe(input int len, input int wr_idx, input int wr_val,
                         output int ons, output int extra, output int flag_end);
        ons   = 0;
        extra = 0;
        for (int i = 0; i < len; i++) begin
            if (pwm_out == ~pol) ons++;
            if (i > 0 && period_flag) extra++;
            duty_wr  = (i == wr_idx);
            duty_din = CW'(wr_val);
            @(negedge clk);
        end
        duty_wr  = 1'b0;
        flag_end = int'(period_flag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ons, extra, fe, pe, cnt, v;
        string tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out at reset pol=1", int'(pwm_out), 0);
        check("R1 flag at reset", int'(period_flag), 0);
        pol = 1'b0;
        #1;
        check("R1 out at reset pol=0", int'(pwm_out), 1);
        @(negedge clk);
        rst = 1'b0;

        // Vector table: R3..R7, R9
        for (int k = 0; k < NV; k++) begin
            program_cfg(int'(VECS[k].r), int'(VECS[k].p), int'(VECS[k].d), VECS[k].pl);
            pe = (VECS[k].p == 0) ? 1 : int'(VECS[k].p);
            if (VECS[k].d == 0)            tag = "R7 zero duty";
            else if (int'(VECS[k].d) > pe)  tag = "R6 over period";
            else if (int'(VECS[k].d) == pe) tag = "R5 coincident";
            else                            tag = "R4 duty";
            probe(pe * int'(VECS[k].r), -1, 0, ons, extra, fe);
            check($sformatf("%s on-count vec%0d", tag, k), ons,
                  ((int'(VECS[k].d) < pe) ? int'(VECS[k].d) : pe) * int'(VECS[k].r));
            check($sformatf("R3 period length vec%0d", k), fe, 1);
            check($sformatf("R9 single flag vec%0d", k), extra, 0);
        end

        // R2: prescaled enable
        program_cfg(3, 4, 2, 1'b0);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            if (cnt_en) cnt++;
            @(negedge clk);
        end
        check("R2 enable count ratio 3", cnt, 10);
        pre_ratio = '0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cnt_en) cnt++;
        end
        check("R2 enable count ratio 0", cnt, 30);

        // R8: mid-period write waits for the boundary
        program_cfg(1, 8, 4, 1'b0);
        probe(8, 2, 6, ons, extra, fe);
        check("R8 current period keeps old duty", ons, 4);
        probe(8, -1, 0, ons, extra, fe);
        check("R8 next period uses new duty", ons, 6);

        // R8: write in the clock of a period end waits one more period
        program_cfg(1, 4, 1, 1'b0);
        probe(4, 3, 3, ons, extra, fe);
        probe(4, -1, 0, ons, extra, fe);
        check("R8 match-clock write not yet active", ons, 1);
        probe(4, -1, 0, ons, extra, fe);
        check("R8 match-clock write active later", ons, 3);

        // R10: polarity acts without a clock edge
        @(negedge clk);
        v   = int'(pwm_out);
        pol = ~pol;
        #1;
        check("R10 immediate polarity", int'(pwm_out), 1 - v);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule